// File: doc/BRIEF.md
# Phase-Programmable Divide-by-Six Interface Clock

This block turns the fast internal system clock into an interface clock at one sixth of its rate, for an external analog front end. A 211.968 MHz system clock gives a 35.328 MHz interface clock. The output is taken straight from a flip-flop, so it has no glitches. Software picks the starting count of the divide-by-six counter with a 3-bit phase value. That sets where the output edges fall relative to the system clock.

The counter runs 0 to 5. The output is high while the count is 0, 1 or 2 and low while it is 3, 4 or 5. Writing the phase alone does not move the running clock. If the write also carries the one-shot bit, the counter is reloaded with the phase one cycle later. This re-aligns the interface clock during operation when synchronous timing to the front end cannot be met. An aligned strobe marks each time the count returns to the phase it was last loaded with, for logic on the interface side.

Top module: `clkdiv6_phase`

## Requirements
- R1: While rst_n is low and right after it rises, div_clk_o is 1 and phase_strobe_o is 0. The counter and the stored phase are both 0.
- R2: Without a one-shot load, the counter advances by one on each system clock edge and goes from 5 back to 0. div_clk_o is high while the count is 0 to 2 and low while it is 3 to 5, so its period is 6 cycles with 3 high and 3 low.
- R3: A write with wr_en=1 stores wr_phase. If wr_oneshot=0, the running counter and both outputs keep the sequence they would have had without the write.
- R4: A write with wr_en=1 and wr_oneshot=1 at edge k loads the counter with the effective phase at edge k+1. At that same edge, div_clk_o becomes 1 if the phase is below 3 and 0 otherwise.
- R5: Stored phase values 6 and 7 act as phase 0 when loaded.
- R6: The one-shot bit is applied exactly once and then clears itself. While wr_en=0, wr_oneshot has no effect.
- R7: phase_strobe_o is high for exactly the cycles in which the counter has just counted, not been loaded, into the phase it was last loaded with. The reset load counts as phase 0. A one-shot load never raises the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_phase | input | 3 | Phase value to store |
| wr_oneshot | input | 1 | Write-1 one-shot re-phase request |
| div_clk_o | output | 1 | Divided interface clock |
| phase_strobe_o | output | 1 | One-cycle strobe when the count returns to the loaded phase |

## Verification
A write sampled at rising edge k is visible in the stored phase and armed bit after edge k. A one-shot load takes effect at edge k+1. div_clk_o and phase_strobe_o are registered from the same next value as the counter, so they change at that same edge. The bench drives inputs on the falling edge and advances a reference model at each rising edge from the inputs it drove. It compares both outputs on the following falling edge, half a cycle after the edge that set them.

// File: rtl/div6_pkg.sv
package div6_pkg;
    localparam int unsigned DIV6_RATIO_DEFAULT = 6;
    localparam int unsigned DIV6_PHASE_W_DEFAULT = 3;

    function automatic int unsigned div6_cnt_width(input int unsigned ratio);
        return (ratio <= 2) ? 1 : $clog2(ratio);
    endfunction
endpackage

// File: rtl/div6_phase_ctrl.sv
module div6_phase_ctrl
    import div6_pkg::*;
#(
    parameter int unsigned DIV_RATIO = DIV6_RATIO_DEFAULT,
    parameter int unsigned PHASE_W   = DIV6_PHASE_W_DEFAULT,
    localparam int unsigned CNT_W    = div6_cnt_width(DIV_RATIO)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] wr_phase,
    input  logic               wr_oneshot,
    output logic               load_o,
    output logic [CNT_W-1:0]   phase_eff_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               armed;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.phase = wr_phase;
            ctrl_d.armed = wr_oneshot;
        end else begin
            ctrl_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_o      = ctrl_q.armed;
    assign phase_eff_o = (int'(ctrl_q.phase) >= int'(DIV_RATIO)) ? '0 : CNT_W'(ctrl_q.phase);
endmodule

// File: rtl/div6_counter.sv
module div6_counter
    import div6_pkg::*;
#(
    parameter int unsigned DIV_RATIO = DIV6_RATIO_DEFAULT,
    localparam int unsigned CNT_W    = div6_cnt_width(DIV_RATIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] phase_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             clk_o,
    output logic             strobe_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIV_RATIO - 1);
    localparam logic [CNT_W-1:0] HIGH_CNT = CNT_W'(DIV_RATIO / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] anchor;
        logic             clk;
        logic             strobe;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (load_i) begin
            div_d.cnt    = phase_i;
            div_d.anchor = phase_i;
            div_d.strobe = 1'b0;
        end else begin
            div_d.cnt    = (div_q.cnt == LAST_CNT) ? '0 : div_q.cnt + 1'b1;
            div_d.strobe = (div_d.cnt == div_q.anchor);
        end
        div_d.clk = (div_d.cnt < HIGH_CNT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q.cnt    <= '0;
            div_q.anchor <= '0;
            div_q.clk    <= 1'b1;
            div_q.strobe <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign cnt_o    = div_q.cnt;
    assign clk_o    = div_q.clk;
    assign strobe_o = div_q.strobe;
endmodule

// File: rtl/clkdiv6_phase.sv
module clkdiv6_phase
    import div6_pkg::*;
#(
    parameter int unsigned DIV_RATIO = DIV6_RATIO_DEFAULT,
    parameter int unsigned PHASE_W   = DIV6_PHASE_W_DEFAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] wr_phase,
    input  logic               wr_oneshot,
    output logic               div_clk_o,
    output logic               phase_strobe_o
);
    localparam int unsigned CNT_W = div6_cnt_width(DIV_RATIO);

    logic             load_w;
    logic [CNT_W-1:0] phase_eff_w;
    logic [CNT_W-1:0] cnt_w;

    div6_phase_ctrl #(
        .DIV_RATIO (DIV_RATIO),
        .PHASE_W   (PHASE_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_phase    (wr_phase),
        .wr_oneshot  (wr_oneshot),
        .load_o      (load_w),
        .phase_eff_o (phase_eff_w)
    );

    div6_counter #(
        .DIV_RATIO (DIV_RATIO)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .phase_i  (phase_eff_w),
        .cnt_o    (cnt_w),
        .clk_o    (div_clk_o),
        .strobe_o (phase_strobe_o)
    );
endmodule

// File: rtl/div6_phase_chk.sv
module div6_phase_chk
    import div6_pkg::*;
#(
    parameter int unsigned DIV_RATIO = DIV6_RATIO_DEFAULT,
    localparam int unsigned CNT_W    = div6_cnt_width(DIV_RATIO)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_oneshot,
    input logic             load,
    input logic [CNT_W-1:0] phase_eff,
    input logic [CNT_W-1:0] cnt,
    input logic             strobe
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIV_RATIO - 1);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_CNT); // R2

    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt == (($past(cnt) == LAST_CNT) ? '0 : $past(cnt) + 1'b1)); // R2

    AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(phase_eff)); // R4

    AST_PHASE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        phase_eff <= LAST_CNT); // R5

    AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !(wr_en && wr_oneshot)) |=> !load); // R6

    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_oneshot) |=> load); // R6

    AST_NO_STROBE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !strobe); // R7
endmodule

bind clkdiv6_phase div6_phase_chk #(
    .DIV_RATIO (DIV_RATIO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_oneshot (wr_oneshot),
    .load       (load_w),
    .phase_eff  (phase_eff_w),
    .cnt        (cnt_w),
    .strobe     (phase_strobe_o)
);

// File: tb/clkdiv6_phase_tb.sv
module clkdiv6_phase_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_phase = '0;
    logic       wr_oneshot = 1'b0;
    logic       div_clk_o;
    logic       phase_strobe_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_anchor = 0, m_phase = 0;
    bit m_armed = 0, m_clk = 1, m_strobe = 0;

    always #10 clk = ~clk;

    clkdiv6_phase u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_phase       (wr_phase),
        .wr_oneshot     (wr_oneshot),
        .div_clk_o      (div_clk_o),
        .phase_strobe_o (phase_strobe_o)
    );

    function automatic int eff_phase(input int p);
        return (p >= 6) ? 0 : p;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit we, input int ph, input bit os);
        int ncnt;
        if (m_armed) begin
            ncnt = eff_phase(m_phase);
            m_anchor = ncnt;
            m_strobe = 0;
        end else begin
            ncnt = (m_cnt == 5) ? 0 : m_cnt + 1;
            m_strobe = (ncnt == m_anchor);
        end
        m_cnt = ncnt;
        m_clk = (ncnt < 3);
        if (we) begin
            m_phase = ph;
            m_armed = os;
        end else begin
            m_armed = 0;
        end
    endtask

    // drive at falling edge, advance at rising edge, compare at next falling edge
    task automatic step(input bit we, input int ph, input bit os, input string tag);
        wr_en = we;
        wr_phase = 3'(ph);
        wr_oneshot = os;
        @(posedge clk);
        model_edge(we, ph, os);
        @(negedge clk);
        chk(tag, "div_clk_o", int'(div_clk_o), int'(m_clk));
        chk(tag, "phase_strobe_o", int'(phase_strobe_o), int'(m_strobe));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, tag);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi_len;
        int lo_len;
        int seen;
        int r;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R1", "div_clk_o in reset", int'(div_clk_o), 1);
        chk("R1", "phase_strobe_o in reset", int'(phase_strobe_o), 0);
        rst_n = 1'b1;

        // R2: free run, measure high and low run lengths at the port
        idle(12, "R2");
        hi_len = 0; lo_len = 0;
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 0, 1'b0, "R2");
            if (div_clk_o) hi_len++; else lo_len++;
        end
        chk("R2", "high cycles per period", hi_len, 3);
        chk("R2", "low cycles per period", lo_len, 3);

        // R3: phase write without one-shot leaves sequence alone
        step(1'b1, 4, 1'b0, "R3");
        idle(8, "R3");

        // R4: one-shot with phase 3, output low right after load
        step(1'b1, 3, 1'b1, "R4");
        step(1'b0, 0, 1'b0, "R4");
        chk("R4", "div_clk_o after load to 3", int'(div_clk_o), 0);
        chk("R4", "strobe after load", int'(phase_strobe_o), 0);
        idle(10, "R7");

        // R5: phase 6 and 7 load as 0
        step(1'b1, 6, 1'b1, "R5");
        step(1'b0, 0, 1'b0, "R5");
        chk("R5", "div_clk_o after load of 6", int'(div_clk_o), 1);
        idle(7, "R5");
        step(1'b1, 7, 1'b1, "R5");
        idle(7, "R5");

        // R6: oneshot without wr_en ignored; one-shot applied only once
        step(1'b1, 5, 1'b1, "R6");
        idle(2, "R6");
        for (int i = 0; i < 8; i++) step(1'b0, 2, 1'b1, "R6");
        // back-to-back one-shots
        step(1'b1, 1, 1'b1, "R6");
        step(1'b1, 4, 1'b1, "R6");
        idle(8, "R6");

        // R7: strobe count over 24 free cycles equals 4
        seen = 0;
        for (int i = 0; i < 24; i++) begin
            step(1'b0, 0, 1'b0, "R7");
            if (phase_strobe_o) seen++;
        end
        chk("R7", "strobes per 24 cycles", seen, 4);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom_range(0, 99));
            if (r < 8) step(1'b1, int'($urandom_range(0, 7)), 1'b1, "R4");
            else if (r < 14) step(1'b1, int'($urandom_range(0, 7)), 1'b0, "R3");
            else if (r < 18) step(1'b0, int'($urandom_range(0, 7)), 1'b1, "R6");
            else step(1'b0, 0, 1'b0, "R2");
        end

        // R1: reset in mid-run returns to reset state
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "div_clk_o after re-reset", int'(div_clk_o), 1);
        chk("R1", "strobe after re-reset", int'(phase_strobe_o), 0);
        m_cnt = 0; m_anchor = 0; m_phase = 0; m_armed = 0; m_clk = 1; m_strobe = 0;
        rst_n = 1'b1;
        idle(12, "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule